// File: doc/BRIEF.md
# Parallel-Access Shift Register with J / K-bar Serial Entry

This block is a register of `WIDTH` stages (default 4) clocked on the rising edge. It has two modes, chosen by one select input. In shift mode the contents move one place toward the last stage. The first stage takes new data through a J-K style entry: a J input and an active-low K input together set, clear, toggle or hold that stage. In load mode every stage takes its parallel data bit, so the block acts as a bank of D flip-flops on a common clock.

An active-low clear acts asynchronously. It empties the register at once, whatever the clock and the other inputs are doing. Besides the true stage outputs, the block drives the complement of the last stage. Tying J and K-bar together gives a plain D serial input. Feeding each stage output back to the parallel input of the stage before it, with load mode held, moves data toward the first stage. The block is used for serial/parallel conversion, simple counters and data storage.

Top module: `sr_pload_jk`

## Requirements
- R1: With `mode_shift`=1, a rising edge moves stage n into stage n+1 for every n from 0 to WIDTH-2.
- R2: With `mode_shift`=0, a rising edge loads `par_d[n]` into `q[n]` for every stage n.
- R3: In shift mode, stage 0 becomes 1 when `ser_j`=1 and `ser_kn`=1, and becomes 0 when `ser_j`=0 and `ser_kn`=0.
- R4: In shift mode, stage 0 inverts when `ser_j`=1 and `ser_kn`=0, and keeps its value when `ser_j`=0 and `ser_kn`=1.
- R5: With `ser_j` and `ser_kn` driven to the same value, stage 0 takes that value on a shift edge, like a D input.
- R6: While `clr_n`=0, `q` is all zeros and `q_last_n` is 1, from the moment `clr_n` falls, through any clock edges and any other input activity.
- R7: `q_last_n` always equals the inverse of `q[WIDTH-1]`.
- R8: The first rising edge after `clr_n` returns high acts normally in the selected mode. No extra recovery cycle is inserted.
- R9: With `par_d` wired to {external bit, `q[WIDTH-1:1]`} and `mode_shift`=0, each edge moves the data one place toward stage 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_shift | input | 1 | 1 = shift toward last stage, 0 = parallel load |
| ser_j | input | 1 | J serial input to stage 0 |
| ser_kn | input | 1 | Active-low K serial input to stage 0 |
| par_d | input | WIDTH | Parallel load data, bit n to stage n |
| q | output | WIDTH | True stage outputs |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The bench covers all four J/K-bar combinations with stage 0 at both 0 and 1. A design with the toggle and hold actions swapped, or that treated K-bar as active high, would leave stage 0 wrong right after the edge. Every parallel pattern is loaded, which exposes a crossed or stuck data bit. Clears are dropped in the middle of a cycle and held across edges while load data of all ones is presented. A synchronous clear, or a clear that loses to the clock, would show nonzero outputs or a low complement during that window. The edge right after release is checked, as is a shift toward stage 0 built from the outputs, and a long random run is compared with a bench model. That run would expose a complement output that drifts from the last stage, for example by missing the clear or by tracking the wrong next value.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } sr_mode_e;

  // J-K entry with active-low K: set, clear, toggle, hold
  function automatic logic jk_next(logic j, logic kn, logic cur);
    return (j & ~cur) | (kn & cur);
  endfunction
endpackage

// File: rtl/sr_jk_entry.sv
module sr_jk_entry (
  input  logic j,
  input  logic kn,
  input  logic cur,
  output logic nxt
);
  import sr_pkg::*;
  always_comb nxt = jk_next(j, kn, cur);
endmodule

// File: rtl/sr_bit_cell.sv
module sr_bit_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic ser_in,
  input  logic par_in,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= RST_VAL;
    else        q <= shift_en ? ser_in : par_in;
  end
endmodule

// File: rtl/sr_pload_jk.sv
module sr_pload_jk #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             mode_shift,
  input  logic             ser_j,
  input  logic             ser_kn,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);
  import sr_pkg::*;
  localparam int LAST = WIDTH - 1;

  sr_mode_e   mode;
  logic       first_nxt;
  logic [WIDTH-1:0] ser_vec;

  always_comb mode = sr_mode_e'(mode_shift);

  sr_jk_entry i_entry (
    .j   (ser_j),
    .kn  (ser_kn),
    .cur (q[0]),
    .nxt (first_nxt)
  );

  generate
    for (genvar n = 0; n < WIDTH; n++) begin : g_stage
      if (n == 0) begin : g_head
        always_comb ser_vec[n] = first_nxt;
      end else begin : g_body
        always_comb ser_vec[n] = q[n-1];
      end
      sr_bit_cell #(.RST_VAL(1'b0)) i_cell (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (mode == MODE_SHIFT),
        .ser_in   (ser_vec[n]),
        .par_in   (par_d[n]),
        .q        (q[n])
      );
    end
  endgenerate

  // separate flop holding the inverted last stage, set by clear
  sr_bit_cell #(.RST_VAL(1'b1)) i_comp (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (mode == MODE_SHIFT),
    .ser_in   (~ser_vec[LAST]),
    .par_in   (~par_d[LAST]),
    .q        (q_last_n)
  );

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
    mode_shift |=> q[LAST:1] == $past(q[LAST-1:0]));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !mode_shift |=> q == $past(par_d));

  // R3
  first_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_shift && ser_j && ser_kn) |=> q[0]);

  // R3
  first_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_shift && !ser_j && !ser_kn) |=> !q[0]);

  // R4
  first_toggle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_shift && ser_j && !ser_kn) |=> q[0] != $past(q[0]));

  // R4
  first_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_shift && !ser_j && ser_kn) |=> $stable(q[0]));

  // R7
  comp_match_chk: assert property (@(posedge clk) disable iff (!clr_n)
    q_last_n == ~q[LAST]);
endmodule

// File: tb/test_sr_pload_jk.sv
`timescale 1ns/100ps
module test_sr_pload_jk;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         mode_shift = 1'b0;
  logic         ser_j = 1'b0;
  logic         ser_kn = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q = '0;

  always #2.5 clk = ~clk;

  sr_pload_jk #(.WIDTH(W)) i_sr_pload_jk (
    .clk(clk), .clr_n(clr_n), .mode_shift(mode_shift),
    .ser_j(ser_j), .ser_kn(ser_kn), .par_d(par_d),
    .q(q), .q_last_n(q_last_n)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, expv);
    end
  endtask

  function automatic logic [W-1:0] model(logic [W-1:0] cur, logic m,
      logic j, logic kn, logic [W-1:0] d);
    logic f;
    if (!m) return d;
    f = (j & ~cur[0]) | (kn & cur[0]);
    return {cur[W-2:0], f};
  endfunction

  // drive at negedge, advance one edge, compare at the next negedge
  task automatic step(string req, logic m, logic j, logic kn, logic [W-1:0] d);
    mode_shift = m; ser_j = j; ser_kn = kn; par_d = d;
    exp_q = model(exp_q, m, j, kn, d);
    @(negedge clk);
    check(req, q, exp_q);
    check("R7", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, ~exp_q[W-1]});
  endtask

  // clear dropped mid-cycle, held across edges with busy inputs
  task automatic pulse_clear(int edges);
    #1 clr_n = 1'b0;
    #0.5;
    check("R6 immediate", q, '0);
    check("R6 comp", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
    exp_q = '0;
    for (int e = 0; e < edges; e++) begin
      mode_shift = 1'b0; par_d = '1; ser_j = 1'b1; ser_kn = 1'b1;
      @(negedge clk);
      check("R6 hold", q, '0);
      check("R6 comp hold", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
    end
    clr_n = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    check("R6 reset state", q, '0);
    check("R6 reset comp", {{(W-1){1'b0}}, q_last_n}, {{(W-1){1'b0}}, 1'b1});
    clr_n = 1'b1;

    // R2: every load pattern
    for (int p = 0; p < (1 << W); p++) step("R2 load", 1'b0, 1'b0, 1'b0, W'(p));

    // R3 / R4: every J/K-bar pair with stage 0 at 0 and at 1
    for (int s = 0; s < 2; s++)
      for (int jk = 0; jk < 4; jk++) begin
        step("R2 preload", 1'b0, 1'b0, 1'b0, s[0] ? 4'b0101 : 4'b1010);
        step((jk == 0 || jk == 3) ? "R3 set/clear" : "R4 toggle/hold",
             1'b1, jk[1], jk[0], 4'b0000);
      end

    // R1: walk a single one through all stages
    step("R2 preload", 1'b0, 1'b0, 1'b0, 4'b0001);
    for (int k = 0; k < W; k++) step("R1 shift", 1'b1, 1'b0, 1'b0, 4'b1111);

    // R5: J and K-bar tied as a D input
    for (int b = 0; b < 8; b++) begin
      logic v;
      v = (b % 3) == 0;
      step("R5 tied D", 1'b1, v, v, 4'b0000);
    end

    // R8: first edge after release behaves normally
    step("R2 preload", 1'b0, 1'b0, 1'b0, 4'b1011);
    pulse_clear(2);
    step("R8 load after release", 1'b0, 1'b0, 1'b0, 4'b0110);
    pulse_clear(1);
    step("R8 shift after release", 1'b1, 1'b1, 1'b1, 4'b0000);

    // R9: shift toward stage 0 with outputs wired to the load inputs
    step("R2 preload", 1'b0, 1'b0, 1'b0, 4'b1001);
    for (int k = 0; k < 6; k++) begin
      logic ext;
      ext = k[0];
      step("R9 shift left", 1'b0, 1'b0, 1'b0, {ext, q[W-1:1]});
    end

    // random run against the model, with clears
    for (int r = 0; r < 3000; r++) begin
      if ($urandom_range(0, 39) == 0) pulse_clear($urandom_range(1, 3));
      else step("R1/R2/R3/R4 random", 1'($urandom), 1'($urandom),
                1'($urandom), W'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule